// File: doc/BRIEF.md
# I2C Target with Strapped Address and Register Pointer

This block is an I2C target that sits on a two-wire bus and gives a bus controller byte access to a small array of internal registers. It answers one 7-bit device address. The upper six bits of that address are a parameter, and an external strap pin supplies the lowest bit, so two copies can share one bus. SCL and SDA are brought into the system clock through a two-flop synchronizer. Start conditions, stop conditions and SCL edges are all found on the synchronized levels. The system clock must run at least eight times faster than SCL.

A write transaction sends the address byte, then one byte that loads the register pointer, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. A read transaction returns the byte at the pointer and advances the pointer after each byte. A repeated start keeps the pointer. This allows a pointer write followed directly by a read. The block never drives SDA high. Its only SDA output is a pull-low enable, which the pad turns into an open-drain driver. It does not stretch the clock. The bus is the only data path, so the block has no stream port and no back-pressure; flow is paced by SCL alone.

Top module: `i2c_strap_target`

## Requirements
- R1: After reset, `sda_pull` is 0, every register holds 0x00 and the pointer is 0. A read issued right after reset, with no pointer byte, returns 0x00.
- R2: The device address is {6'b001110, `addr_strap`}. Strap low gives 0x1C and strap high gives 0x1D. The address byte is the device address followed by a direction bit, where 1 means read and 0 means write. With the strap high this gives 0x3A for a write and 0x3B for a read.
- R3: On a matching address, the block pulls SDA low through the ninth clock of the byte as an ACK. On a mismatch it leaves SDA released (NAK) and ignores every later byte until the next start.
- R4: A start condition is SDA falling while SCL is high. It restarts byte framing even in the middle of a byte, and the next byte is treated as an address. A stop condition is SDA rising while SCL is high. It returns the block to idle, where bytes clocked without a start get no ACK.
- R5: Data bits are sampled on the rising edge of SCL, most significant bit first. In a write, the first byte after the address loads the pointer from its low four bits and is ACKed. The block changes `sda_pull` only while SCL is low.
- R6: Each later write byte is stored at the pointer and ACKed. The pointer then increments modulo 16, so a write at pointer 15 continues at 0.
- R7: In a read, the block drives the register at the pointer MSB first and advances the pointer modulo 16 after each byte. A controller ACK (SDA low on the ninth clock) gets the next byte.
- R8: A controller NAK on the ninth clock of a read byte stops all driving by the block until the next start or stop.
- R9: A repeated start, meaning a start with no stop before it, is accepted and keeps the current pointer.
- R10: `sda_pull` is an active-high pull-low enable. It is 0 in idle, 0 while the block ignores the bus, and 0 one cycle after any start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level from the pad |
| sda_in | input | 1 | Bus data level from the pad (wired-AND line) |
| addr_strap | input | 1 | Selects the lowest bit of the device address |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A bus line change reaches the engine through two synchronizer flops and one previous-level flop. It is seen as an event in the cycle after the second synchronizer flop. The engine registers its response at the next edge, so `sda_pull` changes about three system clocks after the SCL fall that causes it. The bench drives SCL with a quarter period of four system clocks. It sets SDA four clocks into the low phase, and it reads the resolved line twelve clocks after each SCL fall, in the middle of the high phase. That sample always falls after the block's reaction to the previous fall and before the next fall. ACK bits and read data are therefore compared in the same bit slot in which a real controller would sample them.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_WDATA,
    PH_RDATA,
    PH_IGNORE
  } phase_t;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] prev
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        last  <= 1'b1;
      end else begin
        if (STAGES > 1) chain <= {chain[STAGES-2:0], raw[g]};
        else            chain <= raw[g];
        last <= chain[STAGES-1];
      end
    end

    assign lvl[g]  = chain[STAGES-1];
    assign prev[g] = last;
  end

endmodule

// File: rtl/i2cs_cond_detect.sv
module i2cs_cond_detect (
  input  logic scl_lvl,
  input  logic scl_prev,
  input  logic sda_lvl,
  input  logic sda_prev,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_steady_high;

  assign scl_steady_high = scl_lvl & scl_prev;
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_steady_high & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_steady_high & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);

  localparam int AW = $clog2(DEPTH);

  logic [DEPTH-1:0][WIDTH-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [WIDTH-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && (waddr == AW'(g)))    q <= wdata;
    end

    assign cells[g] = q;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int         DEPTH   = 16,
  parameter logic [5:0] ADDR_HI = 6'h0E
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_evt,
  input  logic                     stop_evt,
  input  logic                     sda_lvl,
  input  logic                     strap,
  output logic                     rf_we,
  output logic [$clog2(DEPTH)-1:0] rf_waddr,
  output logic [BYTE_W-1:0]        rf_wdata,
  output logic [$clog2(DEPTH)-1:0] rf_raddr,
  input  logic [BYTE_W-1:0]        rf_rdata,
  output logic                     pull,
  output logic                     in_idle,
  output logic                     in_ignore
);

  localparam int PW = $clog2(DEPTH);
  localparam logic [BIT_CNT_W-1:0] CNT_ACK  = BIT_CNT_W'(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] CNT_DONE = BIT_CNT_W'(BYTE_W + 1);

  phase_t                 phase;
  logic [BIT_CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]      shreg;
  logic [PW-1:0]          ptr;
  logic                   rw;
  logic                   ctrl_nak;
  logic [6:0]             dev_addr;
  logic                   rx_phase;
  logic                   bus_cond;

  assign dev_addr = {ADDR_HI, strap};
  assign rx_phase = (phase == PH_ADDR) || (phase == PH_PTR) || (phase == PH_WDATA);
  assign bus_cond = start_evt | stop_evt;

  assign rf_we    = scl_fall && !bus_cond && (phase == PH_WDATA) && (cnt == CNT_ACK);
  assign rf_waddr = ptr;
  assign rf_wdata = shreg;
  assign rf_raddr = ptr;

  assign in_idle   = (phase == PH_IDLE);
  assign in_ignore = (phase == PH_IGNORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      ctrl_nak <= 1'b0;
      pull     <= 1'b0;
    end else if (stop_evt) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      pull  <= 1'b0;
    end else if (start_evt) begin
      phase <= PH_ADDR;
      cnt   <= '0;
      pull  <= 1'b0;
    end else if (scl_rise) begin
      if (rx_phase) begin
        if (cnt < CNT_ACK) begin
          shreg <= {shreg[BYTE_W-2:0], sda_lvl};
          cnt   <= cnt + 1'b1;
        end else if (cnt == CNT_ACK) begin
          cnt <= CNT_DONE;
        end
      end else if (phase == PH_RDATA) begin
        if (cnt < CNT_ACK) begin
          cnt <= cnt + 1'b1;
        end else if (cnt == CNT_ACK) begin
          ctrl_nak <= sda_lvl;
          cnt      <= CNT_DONE;
        end
      end
    end else if (scl_fall) begin
      if (rx_phase) begin
        if (cnt == CNT_ACK) begin
          unique case (phase)
            PH_ADDR: begin
              if (shreg[BYTE_W-1:1] == dev_addr) begin
                pull <= 1'b1;
                rw   <= shreg[0];
              end else begin
                phase <= PH_IGNORE;
              end
            end
            PH_PTR: begin
              ptr  <= shreg[PW-1:0];
              pull <= 1'b1;
            end
            default: begin
              ptr  <= ptr + 1'b1;
              pull <= 1'b1;
            end
          endcase
        end else if (cnt == CNT_DONE) begin
          cnt  <= '0;
          pull <= 1'b0;
          if (phase == PH_ADDR) begin
            if (rw) begin
              phase <= PH_RDATA;
              shreg <= rf_rdata;
              pull  <= ~rf_rdata[BYTE_W-1];
            end else begin
              phase <= PH_PTR;
            end
          end else if (phase == PH_PTR) begin
            phase <= PH_WDATA;
          end
        end
      end else if (phase == PH_RDATA) begin
        if (cnt == CNT_ACK) begin
          pull <= 1'b0;
          ptr  <= ptr + 1'b1;
        end else if (cnt == CNT_DONE) begin
          cnt <= '0;
          if (ctrl_nak) begin
            phase <= PH_IGNORE;
            pull  <= 1'b0;
          end else begin
            shreg <= rf_rdata;
            pull  <= ~rf_rdata[BYTE_W-1];
          end
        end else if (cnt != '0) begin
          shreg <= {shreg[BYTE_W-2:0], 1'b0};
          pull  <= ~shreg[BYTE_W-2];
        end
      end
    end
  end

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2cs_pkg::*;
#(
  parameter int         DEPTH       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'h0E
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic addr_strap,
  output logic sda_pull
);

  localparam int PW = $clog2(DEPTH);

  logic [1:0]        sync_lvl;
  logic [1:0]        sync_prev;
  logic              scl_lvl, scl_prev, sda_lvl, sda_prev;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic              rf_we;
  logic [PW-1:0]     rf_waddr, rf_raddr;
  logic [BYTE_W-1:0] rf_wdata, rf_rdata;
  logic              in_idle, in_ignore;

  i2cs_line_sync #(
    .STAGES (SYNC_STAGES),
    .LINES  (2)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({sda_in, scl_in}),
    .lvl   (sync_lvl),
    .prev  (sync_prev)
  );

  assign scl_lvl  = sync_lvl[0];
  assign sda_lvl  = sync_lvl[1];
  assign scl_prev = sync_prev[0];
  assign sda_prev = sync_prev[1];

  i2cs_cond_detect u_cond (
    .scl_lvl   (scl_lvl),
    .scl_prev  (scl_prev),
    .sda_lvl   (sda_lvl),
    .sda_prev  (sda_prev),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2cs_engine #(
    .DEPTH   (DEPTH),
    .ADDR_HI (ADDR_HI)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_lvl   (sda_lvl),
    .strap     (addr_strap),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata),
    .rf_raddr  (rf_raddr),
    .rf_rdata  (rf_rdata),
    .pull      (sda_pull),
    .in_idle   (in_idle),
    .in_ignore (in_ignore)
  );

  i2cs_regfile #(
    .DEPTH (DEPTH),
    .WIDTH (BYTE_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic sda_pull,
  input logic scl_lvl,
  input logic scl_prev,
  input logic start_evt,
  input logic stop_evt,
  input logic in_idle,
  input logic in_ignore
);

  assert_start_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull);

  assert_stop_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (in_idle && !sda_pull));

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_pull);

  assert_ignore_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ignore |-> !sda_pull);

  assert_steady_while_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && scl_prev && !start_evt && !stop_evt) |=> $stable(sda_pull));

endmodule

bind i2c_strap_target i2cs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_pull  (sda_pull),
  .scl_lvl   (scl_lvl),
  .scl_prev  (scl_prev),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .in_idle   (in_idle),
  .in_ignore (in_ignore)
);

// File: tb/i2c_strap_target_bench.sv
module i2c_strap_target_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_strap = 1'b1;
  logic sda_pull;
  logic sda_line;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] model [16];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_strap_target u_i2c_strap_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_m),
    .sda_in     (sda_line),
    .addr_strap (addr_strap),
    .sda_pull   (sda_pull)
  );

  // {strap, addr7, ptr4, data8, expect_ack}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 7'h1C, 4'd3,  8'h5A, 1'b1},
    {1'b1, 7'h1D, 4'd7,  8'hC3, 1'b1},
    {1'b1, 7'h1C, 4'd7,  8'h11, 1'b0},
    {1'b0, 7'h1D, 4'd3,  8'hFF, 1'b0},
    {1'b0, 7'h1C, 4'd0,  8'h80, 1'b1},
    {1'b1, 7'h1D, 4'd15, 8'h01, 1'b1},
    {1'b0, 7'h2E, 4'd3,  8'h77, 1'b0},
    {1'b1, 7'h1D, 4'd3,  8'hA5, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qtr();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    qtr(); sda_m = b;
    qtr(); scl_m = 1'b1;
    qtr(); r = sda_line;
    qtr(); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    qtr(); sda_m = 1'b1;
    qtr(); scl_m = 1'b1;
    qtr(); sda_m = 1'b0;
    qtr(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    qtr(); sda_m = 1'b0;
    qtr(); scl_m = 1'b1;
    qtr(); sda_m = 1'b1;
    qtr();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ackd = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      v[i] = r;
    end
    bus_bit(~give_ack, r);
  endtask

  function automatic logic [6:0] own_addr();
    return {6'b001110, addr_strap};
  endfunction

  task automatic read_at(input logic [3:0] p, output logic [7:0] v);
    logic k;
    bus_start();
    send_byte({own_addr(), 1'b0}, k);
    send_byte({4'h0, p}, k);
    bus_start();
    send_byte({own_addr(), 1'b1}, k);
    check("R9 repeated start read ack", k, 1'b1);
    recv_byte(1'b0, v);
    bus_stop();
  endtask

  initial begin
    logic k;
    logic r;
    logic [7:0] v;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;

    repeat (5) @(negedge clk);
    check("R1 sda_pull during reset", sda_pull, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 sda_pull after reset", sda_pull, 1'b0);

    // R1: read with no pointer byte starts at pointer 0
    bus_start();
    send_byte({own_addr(), 1'b1}, k);
    check("R2 read address 0x3B ack", k, 1'b1);
    recv_byte(1'b0, v);
    check("R1 register 0 after reset", v, 8'h00);
    bus_stop();

    // Vector table: write then read back (R2, R3, R5, R6)
    for (int i = 0; i < 8; i++) begin
      logic [3:0] p;
      logic [7:0] d;
      logic ea;
      addr_strap = VEC[i][20];
      p  = VEC[i][12:9];
      d  = VEC[i][8:1];
      ea = VEC[i][0];
      qtr();
      bus_start();
      send_byte({VEC[i][19:13], 1'b0}, k);
      check("R2/R3 address ack", k, ea);
      send_byte({4'h0, p}, k);
      check("R5 pointer byte ack", k, ea);
      send_byte(d, k);
      check("R3/R6 data byte ack", k, ea);
      bus_stop();
      if (ea) model[p] = d;
      read_at(p, v);
      check("R5/R7 readback", v, model[p]);
    end

    addr_strap = 1'b1;

    // R6/R7: write wraps from 15 to 0, read wraps too
    bus_start();
    send_byte({own_addr(), 1'b0}, k);
    send_byte(8'h0F, k);
    send_byte(8'h3C, k);
    check("R6 write at 15 ack", k, 1'b1);
    send_byte(8'h96, k);
    check("R6 write after wrap ack", k, 1'b1);
    bus_stop();
    model[15] = 8'h3C;
    model[0]  = 8'h96;
    bus_start();
    send_byte({own_addr(), 1'b0}, k);
    send_byte(8'h0F, k);
    bus_start();
    send_byte({own_addr(), 1'b1}, k);
    recv_byte(1'b1, v);
    check("R7 read at 15", v, model[15]);
    recv_byte(1'b0, v);
    check("R7 read wraps to 0", v, model[0]);
    bus_stop();

    // R8/R9: pointer kept across repeated start, NAK stops driving
    bus_start();
    send_byte({own_addr(), 1'b0}, k);
    send_byte(8'h03, k);
    bus_start();
    send_byte({own_addr(), 1'b1}, k);
    check("R9 ack after repeated start", k, 1'b1);
    recv_byte(1'b1, v);
    check("R9 pointer kept reg3", v, model[3]);
    recv_byte(1'b0, v);
    check("R7 pointer advanced reg4", v, model[4]);
    begin
      int low_seen = 0;
      for (int i = 0; i < 9; i++) begin
        bus_bit(1'b1, r);
        if (r == 1'b0) low_seen++;
      end
      check("R8 no drive after controller NAK", low_seen, 0);
    end
    bus_stop();

    // R4: start in mid-byte restarts framing
    bus_start();
    bus_bit(1'b1, r);
    bus_bit(1'b0, r);
    bus_bit(1'b1, r);
    bus_start();
    send_byte({own_addr(), 1'b0}, k);
    check("R4 address after mid-byte start", k, 1'b1);
    send_byte(8'h05, k);
    send_byte(8'h42, k);
    bus_stop();
    model[5] = 8'h42;
    read_at(4'd5, v);
    check("R4 data after mid-byte start", v, 8'h42);

    // R4/R10: after stop, a byte without start gets no ACK
    send_byte({own_addr(), 1'b0}, k);
    check("R4 idle ignores bytes", k, 1'b0);
    check("R10 released in idle", sda_pull, 1'b0);

    // R3: data after a mismatched address leaves registers untouched
    bus_start();
    send_byte({7'h1C, 1'b0}, k);
    check("R3 mismatch NAK", k, 1'b0);
    send_byte(8'h05, k);
    send_byte(8'hEE, k);
    check("R3 ignored data NAK", k, 1'b0);
    bus_stop();
    read_at(4'd5, v);
    check("R3 register unchanged", v, model[5]);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-chain actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule